// File: doc/BRIEF.md
# RGB to YCbCr Color Converter

This block sits in a display pipeline between the stage that unpacks pixels from memory and the panel interface. Every clock it may accept one 24-bit RGB pixel together with its valid flag and the line/frame sync and data-enable sideband. It either forwards the pixel untouched or converts it to YCbCr with a programmable 3x3 matrix of signed coefficients and three output offsets. Every result and its sideband leave after exactly three register stages.

A second output carries the converted stream packed as 16-bit 4:2:2 (chroma byte plus luma byte per cycle, Cb on even pixels and Cr on odd ones, both taken from the even pixel of the pair). The packing phase starts afresh at every line. The mode, the packing choice, the coefficients and the offsets are sampled from the configuration inputs only while the incoming vertical sync is high, so a frame never sees mixed settings.

Top module: `rgb_ycc_conv`

## Requirements
- R1: While reset is held, out_valid, out_hsync, out_vsync, out_de, out_pix and out_pix16 are all zero. After reset the active settings are conversion mode, packing off, coefficients Y=(76,150,29), Cb=(-43,-84,128), Cr=(128,-107,-20) for (R,G,B), and offsets Y=0, Cb=128, Cr=128.
- R2: In bypass mode out_pix equals the in_rgb value presented three cycles earlier.
- R3: Coefficient k = row*3 + col sits at cfg_coef[11*k +: 11] as an 11-bit two's-complement value in units of 1/256. Row 0 is Y, 1 is Cb, 2 is Cr; column 0 is R, 1 is G, 2 is B. Offset for row r sits at cfg_offs[11*r +: 11], also 11-bit two's complement.
- R4: In conversion mode each output channel equals floor((sum of coefficient times component + 128) / 256) plus its offset.
- R5: Each converted channel saturates to 0 when the result is negative and to 255 when it exceeds 255.
- R6: out_valid, out_hsync, out_vsync and out_de equal in_valid, in_hsync, in_vsync and in_de from three cycles earlier.
- R7: The configuration inputs are taken into the active settings only on a clock edge where in_vsync is 1; changes at any other time have no effect.
- R8: in_rgb carries R in [23:16], G in [15:8], B in [7:0]; a converted out_pix carries Y in [23:16], Cb in [15:8], Cr in [7:0].
- R9: With packing on and conversion active, each valid pixel with out_de high shows out_pix16 = {Cb, Y} on even pixels and {Cr of the preceding even pixel, Y} on odd pixels. With packing off or in bypass, out_pix16 is zero.
- R10: The even/odd packing phase returns to even after any cycle where out_de is low, so each line starts on an even pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_bypass | input | 1 | Requested mode: 1 forwards RGB unchanged |
| cfg_pack | input | 1 | Requested 16-bit 4:2:2 packing |
| cfg_coef | input | 99 | Nine 11-bit signed matrix coefficients |
| cfg_offs | input | 33 | Three 11-bit signed output offsets |
| in_valid | input | 1 | Input pixel valid |
| in_rgb | input | 24 | Input pixel R,G,B |
| in_hsync | input | 1 | Line sync sideband |
| in_vsync | input | 1 | Frame sync sideband; also the settings load window |
| in_de | input | 1 | Data enable sideband |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 24 | RGB in bypass, Y,Cb,Cr otherwise |
| out_pix16 | output | 16 | Packed 4:2:2 chroma/luma word |
| out_hsync | output | 1 | Delayed line sync |
| out_vsync | output | 1 | Delayed frame sync |
| out_de | output | 1 | Delayed data enable |

## Verification
The matrix is driven with primary colours, white and black under the default coefficients, which separates each row and column since a swapped coefficient or channel changes a distinct output byte. A hand-built matrix with identity, negated and half-weight entries and odd component values exposes sign handling, the rounding constant and offset addition. Extreme coefficients and offsets push every channel past both ends of the range to tell saturation from wrap-around. Streams with gaps in valid, sync pulses and a low data-enable cycle mid-line show alignment of the sideband and the restart of the packing phase, and a settings change without a sync pulse shows the frame-boundary rule.

// File: rtl/ycc_pkg.sv
// Shared constants for the RGB to YCbCr converter.
// Assumes three colour channels and coefficients in 1/256 units.
package ycc_pkg;
    localparam int NCH  = 3;   // channels per pixel
    localparam int FRAC = 8;   // fractional bits of a coefficient
    localparam int LAT  = 3;   // register stages from input to output
    // power-on matrix, row-major (Y, Cb, Cr) x (R, G, B)
    localparam int DEF_COEF [9] = '{76, 150, 29, -43, -84, 128, 128, -107, -20};
    localparam int DEF_OFS  [3] = '{0, 128, 128};
endpackage

// File: rtl/ycc_cfg_shadow.sv
// Active settings of the converter. Copies the requested settings only
// when load is high (vertical sync), so a frame is converted with one
// consistent set. Reset installs the full-range default matrix.
module ycc_cfg_shadow
    import ycc_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  req_byp,
    input  logic                  req_pack,
    input  logic [NCH*NCH*CW-1:0] req_coef,
    input  logic [NCH*CW-1:0]     req_offs,
    output logic                  act_byp,
    output logic                  act_pack,
    output logic [NCH*NCH*CW-1:0] act_coef,
    output logic [NCH*CW-1:0]     act_offs
);
    // hold settings; take new ones only in the frame-boundary window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_byp  <= 1'b0;
            act_pack <= 1'b0;
            for (int k = 0; k < NCH*NCH; k++) act_coef[k*CW +: CW] <= CW'(DEF_COEF[k]);
            for (int r = 0; r < NCH; r++)     act_offs[r*CW +: CW] <= CW'(DEF_OFS[r]);
        end else if (load) begin
            act_byp  <= req_byp;
            act_pack <= req_pack;
            act_coef <= req_coef;
            act_offs <= req_offs;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(act_coef) && $stable(act_offs) && $stable(act_byp) && $stable(act_pack)))
        else $error("settings changed outside frame boundary"); // R7
endmodule

// File: rtl/ycc_matrix.sv
// Three-stage colour matrix. Stage 1 forms the nine products, stage 2
// sums each row with rounding and drops the fraction, stage 3 adds the
// offset and saturates (or forwards the delayed RGB in bypass).
// Assumes coefficients and offsets are held stable by the caller.
module ycc_matrix
    import ycc_pkg::*;
#(
    parameter int PW = 8,
    parameter int CW = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [NCH*PW-1:0]     in_rgb,
    input  logic                  byp,
    input  logic [NCH*NCH*CW-1:0] coef,
    input  logic [NCH*CW-1:0]     offs,
    output logic                  o_valid,
    output logic                  o_byp,
    output logic [NCH*PW-1:0]     o_pix
);
    localparam int PRODW = CW + PW + 1;
    localparam int SUMW  = PRODW + 2;
    localparam int RNDW  = SUMW - FRAC;
    localparam int TW    = RNDW + 1;

    logic              v1, v2, b1, b2;
    logic [NCH*PW-1:0] rgb1, rgb2;
    logic [NCH*PW-1:0] ycc_c;

    // carry valid and mode flag alongside the data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {v1, v2, o_valid} <= '0;
            {b1, b2, o_byp}   <= '0;
        end else begin
            v1 <= in_valid; v2 <= v1; o_valid <= v2;
            b1 <= byp;      b2 <= b1; o_byp   <= b2;
        end
    end

    // delay the raw pixel for the bypass path
    always_ff @(posedge clk) begin
        rgb1 <= in_rgb;
        rgb2 <= rgb1;
    end

    for (genvar r = 0; r < NCH; r++) begin : g_row
        logic signed [PRODW-1:0] prod [NCH];
        logic        [RNDW-1:0]  rnd;
        logic        [SUMW-1:0]  sum;
        logic        [TW-1:0]    t;
        logic        [PW-1:0]    sat;

        // stage 1: coefficient times zero-extended component
        always_ff @(posedge clk) begin
            for (int c = 0; c < NCH; c++)
                prod[c] <= $signed(coef[(r*NCH+c)*CW +: CW])
                         * $signed({1'b0, in_rgb[(NCH-1-c)*PW +: PW]});
        end

        assign sum = SUMW'(prod[0]) + SUMW'(prod[1]) + SUMW'(prod[2])
                   + SUMW'(1 << (FRAC-1));

        // stage 2: rounded row sum with the fraction dropped
        always_ff @(posedge clk) rnd <= sum[SUMW-1:FRAC];

        assign t = {rnd[RNDW-1], rnd}
                 + {{(TW-CW){offs[r*CW+CW-1]}}, offs[r*CW +: CW]};

        // clamp the offset result to the pixel range
        always_comb begin
            if (t[TW-1])            sat = '0;
            else if (|t[TW-2:PW])   sat = '1;
            else                    sat = t[PW-1:0];
        end

        assign ycc_c[(NCH-1-r)*PW +: PW] = sat;

        AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (v2 && !b2 && t[TW-1]) |=> (o_pix[(NCH-1-r)*PW +: PW] == '0))
            else $error("negative channel not clamped to zero"); // R5
    end

    // stage 3: select converted or bypassed pixel
    always_ff @(posedge clk) begin
        if (!rst_n) o_pix <= '0;
        else        o_pix <= b2 ? rgb2 : ycc_c;
    end

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_byp) |-> (o_pix == $past(in_rgb, 3)))
        else $error("bypass altered the pixel"); // R2
endmodule

// File: rtl/ycc_uyvy_pack.sv
// Packs a 4:4:4 YCbCr stream into 16-bit words: {Cb,Y} on even pixels,
// {Cr,Y} on odd pixels with chroma of the even pixel. The phase returns
// to even whenever data enable is low. Output is zero when disabled.
module ycc_uyvy_pack #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          valid,
    input  logic          de,
    input  logic [3*PW-1:0] ycc,
    output logic [2*PW-1:0] pix16
);
    logic          odd;
    logic [PW-1:0] cr_hold;

    // track pixel parity within a line and keep the even pixel's Cr
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd     <= 1'b0;
            cr_hold <= '0;
        end else if (!de) begin
            odd <= 1'b0;
        end else if (valid) begin
            odd <= ~odd;
            if (!odd) cr_hold <= ycc[PW-1:0];
        end
    end

    // choose the chroma byte for this parity
    always_comb begin
        if (!en)      pix16 = '0;
        else if (odd) pix16 = {cr_hold, ycc[3*PW-1 -: PW]};
        else          pix16 = {ycc[2*PW-1 -: PW], ycc[3*PW-1 -: PW]};
    end
endmodule

// File: rtl/rgb_ycc_conv.sv
// Top of the RGB to YCbCr converter: frame-synchronous settings, the
// three-stage matrix, a matching sideband delay and the 4:2:2 packer.
// Assumes in_vsync marks the frame boundary window.
module rgb_ycc_conv
    import ycc_pkg::*;
#(
    parameter int PW = 8,
    parameter int CW = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_bypass,
    input  logic                  cfg_pack,
    input  logic [NCH*NCH*CW-1:0] cfg_coef,
    input  logic [NCH*CW-1:0]     cfg_offs,
    input  logic                  in_valid,
    input  logic [NCH*PW-1:0]     in_rgb,
    input  logic                  in_hsync,
    input  logic                  in_vsync,
    input  logic                  in_de,
    output logic                  out_valid,
    output logic [NCH*PW-1:0]     out_pix,
    output logic [2*PW-1:0]       out_pix16,
    output logic                  out_hsync,
    output logic                  out_vsync,
    output logic                  out_de
);
    logic                  act_byp, act_pack, o_byp;
    logic [NCH*NCH*CW-1:0] act_coef;
    logic [NCH*CW-1:0]     act_offs;
    logic [2:0]            sb [LAT];

    ycc_cfg_shadow #(.CW(CW)) i_shadow (
        .clk(clk), .rst_n(rst_n), .load(in_vsync),
        .req_byp(cfg_bypass), .req_pack(cfg_pack),
        .req_coef(cfg_coef), .req_offs(cfg_offs),
        .act_byp(act_byp), .act_pack(act_pack),
        .act_coef(act_coef), .act_offs(act_offs)
    );

    ycc_matrix #(.PW(PW), .CW(CW)) i_matrix (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rgb(in_rgb),
        .byp(act_byp), .coef(act_coef), .offs(act_offs),
        .o_valid(out_valid), .o_byp(o_byp), .o_pix(out_pix)
    );

    // delay sync and enable by the matrix latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) sb[i] <= '0;
        end else begin
            sb[0] <= {in_hsync, in_vsync, in_de};
            for (int i = 1; i < LAT; i++) sb[i] <= sb[i-1];
        end
    end

    assign {out_hsync, out_vsync, out_de} = sb[LAT-1];

    ycc_uyvy_pack #(.PW(PW)) i_pack (
        .clk(clk), .rst_n(rst_n), .en(act_pack && !o_byp),
        .valid(out_valid), .de(out_de), .ycc(out_pix), .pix16(out_pix16)
    );

    AST_VALID_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3))
        else $error("output valid without input"); // R6
    AST_VALID_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 3) && $past(in_valid, 3)) |-> out_valid)
        else $error("input pixel lost"); // R6
    AST_SIDEBAND_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_de == $past(in_de, 3) && out_hsync == $past(in_hsync, 3)))
        else $error("sideband out of step"); // R6
    AST_PACK_LUMA: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_de && act_pack && !o_byp) |-> (out_pix16[PW-1:0] == out_pix[3*PW-1 -: PW]))
        else $error("packed luma differs from Y"); // R9
endmodule

// File: tb/test_rgb_ycc_conv.sv
module test_rgb_ycc_conv;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bypass, cfg_pack;
    logic [98:0] cfg_coef;
    logic [32:0] cfg_offs;
    logic        in_valid, in_hsync, in_vsync, in_de;
    logic [23:0] in_rgb;
    logic        out_valid, out_hsync, out_vsync, out_de;
    logic [23:0] out_pix;
    logic [15:0] out_pix16;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected active settings
    logic [98:0] b_coef;
    logic [32:0] b_offs;
    logic        b_byp, b_pack;
    int m_k [9];
    int m_o [3];

    // stimulus sequence for streams
    logic [23:0] s_rgb [16];
    logic        s_val [16];
    logic        s_de  [16];
    logic        s_hs  [16];
    logic        s_vs  [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    rgb_ycc_conv i_rgb_ycc_conv (
        .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_pack(cfg_pack),
        .cfg_coef(cfg_coef), .cfg_offs(cfg_offs), .in_valid(in_valid),
        .in_rgb(in_rgb), .in_hsync(in_hsync), .in_vsync(in_vsync), .in_de(in_de),
        .out_valid(out_valid), .out_pix(out_pix), .out_pix16(out_pix16),
        .out_hsync(out_hsync), .out_vsync(out_vsync), .out_de(out_de)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int sx11(input logic [10:0] v);
        return v[10] ? int'(v) - 2048 : int'(v);
    endfunction

    // conversion model written from R3, R4, R5, R8
    function automatic logic [23:0] exp_ycc(input logic [23:0] rgb);
        logic [23:0] res;
        for (int r = 0; r < 3; r++) begin
            int s = 0;
            for (int c = 0; c < 3; c++)
                s += sx11(b_coef[(r*3+c)*11 +: 11]) * int'(rgb[(2-c)*8 +: 8]);
            s = (s + 128) >>> 8;
            s += sx11(b_offs[r*11 +: 11]);
            if (s < 0) s = 0;
            if (s > 255) s = 255;
            res[(2-r)*8 +: 8] = 8'(s);
        end
        return res;
    endfunction

    task automatic idle();
        in_valid = 0; in_rgb = '0; in_hsync = 0; in_vsync = 0; in_de = 0;
    endtask

    task automatic drive_cfg(input logic byp, input logic pk);
        for (int k = 0; k < 9; k++) cfg_coef[k*11 +: 11] = 11'(m_k[k]);
        for (int r = 0; r < 3; r++) cfg_offs[r*11 +: 11] = 11'(m_o[r]);
        cfg_bypass = byp;
        cfg_pack   = pk;
    endtask

    // present settings and open the frame-boundary window for one cycle
    task automatic load_cfg(input logic byp, input logic pk);
        @(negedge clk);
        drive_cfg(byp, pk);
        idle();
        in_vsync = 1;
        @(negedge clk);
        idle();
        b_coef = cfg_coef; b_offs = cfg_offs; b_byp = byp; b_pack = pk;
        repeat (3) @(negedge clk);
    endtask

    // run n stimulus entries and check each result three cycles later
    task automatic run_stream(input int n, input string req);
        logic       ph = 1'b0;
        logic [7:0] crh = '0;
        for (int i = 0; i < n + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                int j = i - 3;
                logic [23:0] e = b_byp ? s_rgb[j] : exp_ycc(s_rgb[j]);
                check({req, " R6 valid"}, 32'(out_valid), 32'(s_val[j]));
                check({req, " R6 de"}, 32'(out_de), 32'(s_de[j]));
                check({req, " R6 hsync"}, 32'(out_hsync), 32'(s_hs[j]));
                check({req, " R6 vsync"}, 32'(out_vsync), 32'(s_vs[j]));
                if (s_val[j]) begin
                    check({req, " R8 pix"}, 32'(out_pix), 32'(e));
                    if (s_de[j]) begin
                        logic [15:0] e16;
                        if (!(b_pack && !b_byp)) e16 = '0;
                        else if (ph) e16 = {crh, e[23:16]};
                        else         e16 = {e[15:8], e[23:16]};
                        check({req, " R9 pix16"}, 32'(out_pix16), 32'(e16));
                    end
                end
                if (!s_de[j]) ph = 1'b0;
                else if (s_val[j]) begin
                    if (!ph) crh = e[7:0];
                    ph = ~ph;
                end
            end
            if (i < n) begin
                in_valid = s_val[i]; in_rgb = s_rgb[i]; in_de = s_de[i];
                in_hsync = s_hs[i]; in_vsync = s_vs[i];
            end else begin
                idle();
            end
        end
    endtask

    task automatic set_px(input int i, input logic [23:0] rgb, input logic v,
                          input logic de, input logic hs, input logic vs);
        s_rgb[i] = rgb; s_val[i] = v; s_de[i] = de; s_hs[i] = hs; s_vs[i] = vs;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset valid", 32'(out_valid), 0);
        check("R1 reset pix", 32'(out_pix), 0);
        check("R1 reset pix16", 32'(out_pix16), 0);
        check("R1 reset sync", 32'({out_hsync, out_vsync, out_de}), 0);
    endtask

    // defaults active after reset; cfg inputs differ but are not loaded (R7)
    task automatic t_defaults();
        set_px(0, 24'hFF0000, 1, 1, 0, 0);
        set_px(1, 24'h00FF00, 1, 1, 0, 0);
        set_px(2, 24'h0000FF, 1, 1, 0, 0);
        set_px(3, 24'hFFFFFF, 1, 1, 0, 0);
        set_px(4, 24'h000000, 1, 1, 0, 0);
        set_px(5, 24'h806040, 1, 1, 0, 0);
        run_stream(6, "R1 R4 defaults");
    endtask

    task automatic t_bypass();
        m_k = '{76, 150, 29, -43, -84, 128, 128, -107, -20};
        m_o = '{0, 128, 128};
        load_cfg(1, 0);
        set_px(0, 24'h123456, 1, 1, 0, 0);
        set_px(1, 24'hABCDEF, 1, 0, 1, 0);
        set_px(2, 24'h000000, 0, 0, 1, 1);
        set_px(3, 24'hFEDCBA, 1, 1, 0, 1);
        set_px(4, 24'h010203, 1, 1, 1, 0);
        run_stream(5, "R2 bypass");
    endtask

    // identity, negation and half weight expose sign, rounding, offset
    task automatic t_matrix();
        m_k = '{256, 0, 0, 0, -256, 0, 0, 0, 128};
        m_o = '{0, 255, 0};
        load_cfg(0, 0);
        set_px(0, 24'h11_22_01, 1, 1, 0, 0);
        set_px(1, 24'hF0_0F_03, 1, 1, 0, 0);
        set_px(2, 24'h7F_80_FF, 1, 1, 0, 0);
        set_px(3, 24'h00_FF_02, 1, 1, 0, 0);
        run_stream(4, "R3 R4 matrix");
        m_k = '{-3, 5, 7, 100, -1, -100, 1, 1, 1};
        m_o = '{10, -10, 3};
        load_cfg(0, 0);
        set_px(0, 24'h10_20_30, 1, 1, 0, 0);
        set_px(1, 24'hC8_05_64, 1, 1, 0, 0);
        set_px(2, 24'hFF_FF_FF, 1, 1, 0, 0);
        run_stream(3, "R3 R4 signed");
    endtask

    task automatic t_saturate();
        m_k = '{1023, 1023, 1023, -1024, -1024, -1024, 0, 0, 0};
        m_o = '{0, 0, 300};
        load_cfg(0, 0);
        set_px(0, 24'hFFFFFF, 1, 1, 0, 0);
        set_px(1, 24'h010101, 1, 1, 0, 0);
        set_px(2, 24'h000000, 1, 1, 0, 0);
        run_stream(3, "R5 saturate");
        @(negedge clk);
        check("R5 sat high then low fields", 32'(exp_ycc(24'hFFFFFF)), 32'h FF00FF);
    endtask

    // requests without a sync window must not take effect
    task automatic t_frozen();
        m_k = '{0, 0, 0, 0, 0, 0, 0, 0, 0};
        m_o = '{5, 5, 5};
        @(negedge clk);
        drive_cfg(1, 1);
        set_px(0, 24'h405060, 1, 1, 0, 0);
        set_px(1, 24'hFFFFFF, 1, 1, 0, 0);
        run_stream(2, "R7 frozen");
        b_coef = cfg_coef; b_offs = cfg_offs; b_byp = 1; b_pack = 1;
        @(negedge clk);
        idle(); in_vsync = 1;
        @(negedge clk);
        idle();
        repeat (3) @(negedge clk);
        set_px(0, 24'h405060, 1, 1, 0, 0);
        run_stream(1, "R7 loaded");
    endtask

    task automatic t_pack();
        m_k = '{76, 150, 29, -43, -84, 128, 128, -107, -20};
        m_o = '{0, 128, 128};
        load_cfg(0, 1);
        set_px(0, 24'hFF0000, 1, 1, 0, 0);
        set_px(1, 24'h00FF00, 1, 1, 0, 0);
        set_px(2, 24'h0000FF, 1, 1, 0, 0);
        set_px(3, 24'h000000, 0, 1, 0, 0);
        set_px(4, 24'h808080, 1, 1, 0, 0);
        set_px(5, 24'h000000, 1, 0, 1, 0);
        set_px(6, 24'h20E040, 1, 1, 0, 0);
        set_px(7, 24'hE02040, 1, 1, 0, 0);
        run_stream(8, "R9 R10 pack");
        @(negedge clk);
        idle();
        // explicit line restart: after three pixels a low enable, then even again
        set_px(0, 24'h102030, 1, 1, 0, 0);
        set_px(1, 24'h405060, 1, 1, 0, 0);
        set_px(2, 24'h708090, 1, 1, 0, 0);
        set_px(3, 24'h000000, 0, 0, 0, 0);
        set_px(4, 24'hA0B0C0, 1, 1, 0, 0);
        run_stream(5, "R10 line restart");
        load_cfg(1, 1);
        set_px(0, 24'h5A5A5A, 1, 1, 0, 0);
        set_px(1, 24'hA5A5A5, 1, 1, 0, 0);
        run_stream(2, "R9 bypass zero");
    endtask

    initial begin
        idle();
        m_k = '{76, 150, 29, -43, -84, 128, 128, -107, -20};
        m_o = '{0, 128, 128};
        drive_cfg(0, 0);
        b_coef = cfg_coef; b_offs = cfg_offs; b_byp = 0; b_pack = 0;
        // requests during the first frame differ from the defaults
        cfg_bypass = 1; cfg_pack = 1; cfg_coef = '0; cfg_offs = '0;
        repeat (4) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_defaults();
        t_bypass();
        t_matrix();
        t_saturate();
        t_frozen();
        t_pack();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R6: watchdog expired, actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule